// File: doc/BRIEF.md
# Accumulator Arithmetic and Logic Unit

This unit is the execute stage of a small accumulator machine. It holds an 8-bit accumulator and four status flags. On each strobed cycle it combines the accumulator with one explicit operand and, when the operation calls for it, writes the result back. The operand may come from a register, from memory or from an immediate field, but it always arrives on the same input port. Operand fetch, instruction decode and the register file are outside this block.

The operation set has five combining operations: add, subtract, AND, OR and exclusive OR. It also has two flag-only probes, compare and test, which leave the accumulator untouched. The rest are a one-bit rotate in each direction and a decimal correction that turns a binary sum into two packed BCD digits. The `acc_next` port shows the computed value combinationally, including the discarded difference of a compare. The `acc_we` port reports whether that value will be stored. Following stages use the flags, for example a zero test for a conditional branch.

There is no control sequence. Every operation finishes in the cycle it is presented. The design is one combinational decode and select process, feeding one register process that holds the accumulator and the flags.

Top module: `acc_alu`

## Requirements
- R1: Opcode 0 (add), 1 (subtract, accumulator minus operand), 2 (AND), 3 (OR) and 4 (exclusive OR) with `op_valid` high assert `acc_we` and load the 8-bit result into `acc_q` at the clock edge.
- R2: Opcode 5 (compare) computes accumulator minus operand and updates all four flags from it. It keeps `acc_we` low and leaves `acc_q` unchanged.
- R3: Opcode 6 (test) ANDs accumulator and operand and updates the flags from that value, with carry and auxiliary carry cleared. It keeps `acc_we` low and leaves `acc_q` unchanged.
- R4: Opcode 7 (rotate left) moves bit 7 into both bit 0 and carry. Opcode 8 (rotate right) moves bit 0 into both bit 7 and carry. Both write the accumulator and clear auxiliary carry.
- R5: Opcode 9 (decimal correction) first adds 0x06 when the low nibble exceeds 9 or auxiliary carry is set. It then adds 0x60 when the high nibble of that sum exceeds 9 or carry is set, and it sets carry whenever the 0x60 step is applied. Otherwise carry keeps its old value. Auxiliary carry becomes the carry out of bit 3 of the first step.
- R6: After any defined operation, `flag_z` is 1 exactly when the computed 8-bit value is zero.
- R7: `flag_s` takes bit 7 of the computed value. For add, `flag_c` is the carry out of bit 7 and `flag_ac` the carry out of bit 3. For subtract and compare, `flag_c` is a borrow (operand greater than accumulator) and `flag_ac` a borrow from the low nibble. The logic operations clear both carries.
- R8: A rotate takes its input from the accumulator as stored before the edge, so back-to-back rotates move the value one position per strobed cycle.
- R9: With `op_valid` low, `acc_we` is low and neither `acc_q` nor any flag changes.
- R10: A synchronous reset clears `acc_q` and all flags, even if `op_valid` is high in the same cycle.
- R11: Opcodes 10 to 15 are undefined. They keep `acc_we` low and change neither `acc_q` nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Strobe: execute the opcode on this edge |
| op_code | input | 4 | Operation select |
| operand | input | 8 | Explicit operand |
| acc_q | output | 8 | Current accumulator |
| acc_next | output | 8 | Computed value for the presented opcode |
| acc_we | output | 1 | Computed value will be written this edge |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_c | output | 1 | Carry / borrow flag |
| flag_ac | output | 1 | Auxiliary carry (bit 3) flag |

## Verification
The bench builds the block with its default `DATA_W` of 8. Only this width gives two packed BCD digits, so only this width brings the decimal-correction paths within reach. These are a low-only correction, a correction driven by auxiliary carry, one driven by carry, and a double correction that wraps to zero. Preloading through add lets the checks reach the carry and borrow limits of the byte, the compare and test probes that hold the accumulator, and a reset that wins over a strobe in the same cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    typedef enum logic [3:0] {
        OPC_ADD = 4'd0,
        OPC_SUB = 4'd1,
        OPC_AND = 4'd2,
        OPC_OR  = 4'd3,
        OPC_XOR = 4'd4,
        OPC_CMP = 4'd5,
        OPC_TST = 4'd6,
        OPC_ROL = 4'd7,
        OPC_ROR = 4'd8,
        OPC_DEC = 4'd9
    } acc_op_e;

    typedef enum logic [1:0] {
        BOP_AND = 2'd0,
        BOP_OR  = 2'd1,
        BOP_XOR = 2'd2
    } bit_op_e;

    typedef struct packed {
        logic z;
        logic s;
        logic c;
        logic ac;
    } acc_flags_t;

endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              do_sub,
    output logic [DATA_W-1:0] res,
    output logic              carry,
    output logic              aux
);
    logic [DATA_W:0] full;
    logic [NIB_W:0]  low;

    always_comb begin
        if (do_sub) begin
            full = {1'b0, a} - {1'b0, b};
            low  = {1'b0, a[NIB_W-1:0]} - {1'b0, b[NIB_W-1:0]};
        end else begin
            full = {1'b0, a} + {1'b0, b};
            low  = {1'b0, a[NIB_W-1:0]} + {1'b0, b[NIB_W-1:0]};
        end
        res   = full[DATA_W-1:0];
        carry = full[DATA_W];
        aux   = low[NIB_W];
    end
endmodule

// File: rtl/acc_alu_bitops.sv
module acc_alu_bitops
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  bit_op_e           sel,
    output logic [DATA_W-1:0] logic_res,
    output logic [DATA_W-1:0] rol_res,
    output logic [DATA_W-1:0] ror_res,
    output logic              rol_out,
    output logic              ror_out
);
    always_comb begin
        unique case (sel)
            BOP_AND: logic_res = a & b;
            BOP_OR:  logic_res = a | b;
            BOP_XOR: logic_res = a ^ b;
            default: logic_res = a & b;
        endcase
        rol_res = {a[DATA_W-2:0], a[DATA_W-1]};
        ror_res = {a[0], a[DATA_W-1:1]};
        rol_out = a[DATA_W-1];
        ror_out = a[0];
    end
endmodule

// File: rtl/acc_alu_decadj.sv
module acc_alu_decadj #(
    parameter int DATA_W = 8,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] a,
    input  logic              c_in,
    input  logic              ac_in,
    output logic [DATA_W-1:0] res,
    output logic              c_out,
    output logic              ac_out
);
    localparam int            HI_LSB  = NIB_W;
    localparam logic [NIB_W-1:0] DIG_MAX = NIB_W'(9);
    localparam logic [NIB_W-1:0] DIG_FIX = NIB_W'(6);

    logic              lo_fix;
    logic              hi_fix;
    logic [NIB_W:0]    lo_sum;
    logic [DATA_W-1:0] step1;

    always_comb begin
        lo_fix = (a[NIB_W-1:0] > DIG_MAX) || ac_in;
        lo_sum = {1'b0, a[NIB_W-1:0]} + (lo_fix ? {1'b0, DIG_FIX} : '0);
        step1  = a + (lo_fix ? DATA_W'(DIG_FIX) : '0);
        hi_fix = (step1[HI_LSB +: NIB_W] > DIG_MAX) || c_in;
        res    = step1 + (hi_fix ? (DATA_W'(DIG_FIX) << HI_LSB) : '0);
        c_out  = hi_fix ? 1'b1 : c_in;
        ac_out = lo_sum[NIB_W];
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int OP_W   = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] acc_q,
    output logic [DATA_W-1:0] acc_next,
    output logic              acc_we,
    output logic              flag_z,
    output logic              flag_s,
    output logic              flag_c,
    output logic              flag_ac
);
    localparam int NIB_W = DATA_W / 2;

    acc_flags_t        flags_q;
    acc_flags_t        flags_d;
    logic              flags_we;
    logic [DATA_W-1:0] acc_r;

    logic              as_sub;
    logic [DATA_W-1:0] as_res;
    logic              as_c;
    logic              as_ac;
    bit_op_e           bsel;
    logic [DATA_W-1:0] lg_res;
    logic [DATA_W-1:0] rl_res;
    logic [DATA_W-1:0] rr_res;
    logic              rl_c;
    logic              rr_c;
    logic [DATA_W-1:0] da_res;
    logic              da_c;
    logic              da_ac;

    acc_op_e           op;
    assign op = acc_op_e'(op_code);

    assign as_sub = (op == OPC_SUB) || (op == OPC_CMP);

    acc_alu_addsub #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_addsub (
        .a      (acc_r),
        .b      (operand),
        .do_sub (as_sub),
        .res    (as_res),
        .carry  (as_c),
        .aux    (as_ac)
    );

    always_comb begin
        unique case (op)
            OPC_OR:  bsel = BOP_OR;
            OPC_XOR: bsel = BOP_XOR;
            default: bsel = BOP_AND;
        endcase
    end

    acc_alu_bitops #(.DATA_W(DATA_W)) u_bitops (
        .a         (acc_r),
        .b         (operand),
        .sel       (bsel),
        .logic_res (lg_res),
        .rol_res   (rl_res),
        .ror_res   (rr_res),
        .rol_out   (rl_c),
        .ror_out   (rr_c)
    );

    acc_alu_decadj #(.DATA_W(DATA_W), .NIB_W(NIB_W)) u_decadj (
        .a      (acc_r),
        .c_in   (flags_q.c),
        .ac_in  (flags_q.ac),
        .res    (da_res),
        .c_out  (da_c),
        .ac_out (da_ac)
    );

    // Output process: select result, write intent and next flags.
    always_comb begin
        acc_next = acc_r;
        acc_we   = 1'b0;
        flags_we = 1'b0;
        flags_d  = flags_q;
        unique case (op)
            OPC_ADD, OPC_SUB: begin
                acc_next   = as_res;
                acc_we     = op_valid;
                flags_we   = op_valid;
                flags_d.c  = as_c;
                flags_d.ac = as_ac;
            end
            OPC_CMP: begin
                acc_next   = as_res;
                flags_we   = op_valid;
                flags_d.c  = as_c;
                flags_d.ac = as_ac;
            end
            OPC_AND, OPC_OR, OPC_XOR: begin
                acc_next   = lg_res;
                acc_we     = op_valid;
                flags_we   = op_valid;
                flags_d.c  = 1'b0;
                flags_d.ac = 1'b0;
            end
            OPC_TST: begin
                acc_next   = lg_res;
                flags_we   = op_valid;
                flags_d.c  = 1'b0;
                flags_d.ac = 1'b0;
            end
            OPC_ROL: begin
                acc_next   = rl_res;
                acc_we     = op_valid;
                flags_we   = op_valid;
                flags_d.c  = rl_c;
                flags_d.ac = 1'b0;
            end
            OPC_ROR: begin
                acc_next   = rr_res;
                acc_we     = op_valid;
                flags_we   = op_valid;
                flags_d.c  = rr_c;
                flags_d.ac = 1'b0;
            end
            OPC_DEC: begin
                acc_next   = da_res;
                acc_we     = op_valid;
                flags_we   = op_valid;
                flags_d.c  = da_c;
                flags_d.ac = da_ac;
            end
            default: begin
                acc_next = acc_r;
            end
        endcase
        flags_d.z = (acc_next == '0);
        flags_d.s = acc_next[DATA_W-1];
    end

    // Register process: accumulator and flags.
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_r   <= '0;
            flags_q <= '0;
        end else begin
            if (acc_we)   acc_r   <= acc_next;
            if (flags_we) flags_q <= flags_d;
        end
    end

    assign acc_q   = acc_r;
    assign flag_z  = flags_q.z;
    assign flag_s  = flags_q.s;
    assign flag_c  = flags_q.c;
    assign flag_ac = flags_q.ac;
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk #(
    parameter int DATA_W = 8,
    parameter int OP_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [OP_W-1:0]   op_code,
    input logic [DATA_W-1:0] operand,
    input logic [DATA_W-1:0] acc_q,
    input logic [DATA_W-1:0] acc_next,
    input logic              acc_we,
    input logic              flag_z,
    input logic              flag_s,
    input logic              flag_c,
    input logic              flag_ac
);
    logic defined_op;
    assign defined_op = (op_code <= OP_W'(9));

    a_r1_write_lands: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code <= OP_W'(4)) |=> (acc_q == $past(acc_next)));

    a_r2_cmp_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_W'(5)) |-> !acc_we ##1 $stable(acc_q));

    a_r3_tst_keeps_acc: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_W'(6)) |=> $stable(acc_q));

    a_r4_rol_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_W'(7)) |=> (flag_c == $past(acc_q[DATA_W-1])));

    a_r4_ror_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == OP_W'(8)) |=> (flag_c == $past(acc_q[0])));

    a_r6_zero_flag: assert property (@(posedge clk) disable iff (rst)
        (op_valid && defined_op) |=> (flag_z == ($past(acc_next) == '0)));

    a_r7_sign_flag: assert property (@(posedge clk) disable iff (rst)
        (op_valid && defined_op) |=> (flag_s == $past(acc_next[DATA_W-1])));

    a_r9_idle_holds: assert property (@(posedge clk) disable iff (rst)
        !op_valid |-> !acc_we ##1 ($stable(acc_q) && $stable({flag_z, flag_s, flag_c, flag_ac})));

    a_r10_reset_clears: assert property (@(posedge clk)
        rst |=> (acc_q == '0 && {flag_z, flag_s, flag_c, flag_ac} == 4'b0000));

    a_r11_undef_holds: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !defined_op) |-> !acc_we ##1 ($stable(acc_q) && $stable({flag_z, flag_s, flag_c, flag_ac})));
endmodule

bind acc_alu acc_alu_chk #(.DATA_W(DATA_W), .OP_W(OP_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .op_valid (op_valid),
    .op_code  (op_code),
    .operand  (operand),
    .acc_q    (acc_q),
    .acc_next (acc_next),
    .acc_we   (acc_we),
    .flag_z   (flag_z),
    .flag_s   (flag_s),
    .flag_c   (flag_c),
    .flag_ac  (flag_ac)
);

// File: tb/sim_acc_alu.sv
module sim_acc_alu;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    localparam logic [3:0] K_ADD = 4'd0, K_SUB = 4'd1, K_AND = 4'd2, K_OR = 4'd3,
                           K_XOR = 4'd4, K_CMP = 4'd5, K_TST = 4'd6, K_ROL = 4'd7,
                           K_ROR = 4'd8, K_DEC = 4'd9;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          op_valid = 1'b0;
    logic [3:0]    op_code = '0;
    logic [DW-1:0] operand = '0;
    logic [DW-1:0] acc_q;
    logic [DW-1:0] acc_next;
    logic          acc_we;
    logic          flag_z, flag_s, flag_c, flag_ac;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    acc_alu #(.DATA_W(DW)) u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .operand(operand), .acc_q(acc_q), .acc_next(acc_next), .acc_we(acc_we),
        .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c), .flag_ac(flag_ac)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // state after an edge: accumulator and flags {z,s,c,ac}
    task automatic chk_state(input string req, input logic [DW-1:0] ea, input logic [3:0] ef);
        chk(req, "acc_q", int'(acc_q), int'(ea));
        chk(req, "flags zsc-ac", int'({flag_z, flag_s, flag_c, flag_ac}), int'(ef));
    endtask

    // presents one operation for one edge; checks write intent before the edge
    task automatic run_op(input string req, input logic [3:0] oc, input logic [DW-1:0] b,
                          input logic ew);
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = oc;
        operand  = b;
        #1;
        chk(req, "acc_we", int'(acc_we), int'(ew));
        @(posedge clk);
        #1;
        op_valid = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        op_valid = 1'b0;
        @(posedge clk);
        #1;
        rst = 1'b0;
    endtask

    task automatic preload(input logic [DW-1:0] v);
        do_reset();
        run_op("R1", K_ADD, v, 1'b1);
    endtask

    task automatic t_reset();
        do_reset();
        chk_state("R10", 8'h00, 4'b0000);
    endtask

    task automatic t_add();
        preload(8'h3A);
        run_op("R1", K_ADD, 8'hC8, 1'b1);
        chk_state("R7", 8'h02, 4'b0011);
        preload(8'h80);
        run_op("R6", K_ADD, 8'h80, 1'b1);
        chk_state("R6", 8'h00, 4'b1010);
    endtask

    task automatic t_sub();
        preload(8'h10);
        run_op("R1", K_SUB, 8'h01, 1'b1);
        chk_state("R7", 8'h0F, 4'b0001);
        run_op("R1", K_SUB, 8'h20, 1'b1);
        chk_state("R7", 8'hEF, 4'b0110);
    endtask

    task automatic t_cmp();
        preload(8'h42);
        run_op("R2", K_CMP, 8'h42, 1'b0);
        chk_state("R2", 8'h42, 4'b1000);
        run_op("R2", K_CMP, 8'h50, 1'b0);
        chk_state("R2", 8'h42, 4'b0110);
    endtask

    task automatic t_logic();
        preload(8'hF0);
        run_op("R1", K_AND, 8'h3C, 1'b1);
        chk_state("R1", 8'h30, 4'b0000);
        run_op("R1", K_OR, 8'h0F, 1'b1);
        chk_state("R1", 8'h3F, 4'b0000);
        run_op("R1", K_XOR, 8'hFF, 1'b1);
        chk_state("R1", 8'hC0, 4'b0100);
    endtask

    task automatic t_test();
        preload(8'hC0);
        run_op("R3", K_TST, 8'h3F, 1'b0);
        chk_state("R3", 8'hC0, 4'b1000);
        run_op("R3", K_TST, 8'h80, 1'b0);
        chk_state("R3", 8'hC0, 4'b0100);
    endtask

    task automatic t_rotate();
        preload(8'h81);
        run_op("R4", K_ROL, 8'h00, 1'b1);
        chk_state("R4", 8'h03, 4'b0010);
        run_op("R8", K_ROR, 8'h00, 1'b1);
        chk_state("R8", 8'h81, 4'b0110);
        run_op("R8", K_ROR, 8'h00, 1'b1);
        chk_state("R8", 8'hC0, 4'b0110);
        preload(8'h02);
        run_op("R4", K_ROR, 8'h00, 1'b1);
        chk_state("R4", 8'h01, 4'b0000);
    endtask

    task automatic t_decimal();
        preload(8'h15);
        run_op("R5", K_ADD, 8'h27, 1'b1);
        run_op("R5", K_DEC, 8'h00, 1'b1);
        chk_state("R5 low fix", 8'h42, 4'b0001);
        preload(8'h19);
        run_op("R5", K_ADD, 8'h28, 1'b1);
        run_op("R5", K_DEC, 8'h00, 1'b1);
        chk_state("R5 aux fix", 8'h47, 4'b0000);
        preload(8'h91);
        run_op("R5", K_ADD, 8'h91, 1'b1);
        run_op("R5", K_DEC, 8'h00, 1'b1);
        chk_state("R5 carry fix", 8'h82, 4'b0110);
        preload(8'h99);
        run_op("R5", K_ADD, 8'h01, 1'b1);
        run_op("R5", K_DEC, 8'h00, 1'b1);
        chk_state("R5 double fix", 8'h00, 4'b1011);
    endtask

    task automatic t_idle();
        preload(8'h8F);
        @(negedge clk);
        op_valid = 1'b0;
        op_code  = K_ADD;
        operand  = 8'hFF;
        #1;
        chk("R9", "acc_we", int'(acc_we), 0);
        @(posedge clk);
        #1;
        chk_state("R9", 8'h8F, 4'b0100);
    endtask

    task automatic t_undef();
        preload(8'h8F);
        for (int k = 10; k < 16; k++) begin
            run_op("R11", 4'(k), 8'h71, 1'b0);
            chk_state("R11", 8'h8F, 4'b0100);
        end
    endtask

    task automatic t_reset_wins();
        preload(8'h55);
        @(negedge clk);
        rst = 1'b1;
        op_valid = 1'b1;
        op_code  = K_ADD;
        operand  = 8'hFF;
        @(posedge clk);
        #1;
        rst = 1'b0;
        op_valid = 1'b0;
        chk_state("R10", 8'h00, 4'b0000);
    endtask

    initial begin
        repeat (2) @(posedge clk);
        t_reset();
        t_add();
        t_sub();
        t_cmp();
        t_logic();
        t_test();
        t_rotate();
        t_decimal();
        t_idle();
        t_undef();
        t_reset_wins();
        finished = 1'b1;
    end

    initial begin
        for (int n = 0; n < 20000; n++) begin
            @(posedge clk);
            if (finished) break;
        end
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=hung expected=done");
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule